// File: doc/BRIEF.md
# Port Pin-Event Interrupt Detector

This block watches the eight already-synchronized input levels of one general-purpose I/O port. For each pin it decides from a 24-bit trigger word whether the pin is level- or edge-sensed, which level or edge counts, and whether both edges count. When the selected condition occurs, the block sets a status bit for that pin. The status bit stays set until software writes a 1 to that pin's position in a write-1-to-clear register. An enable register gates the status bits, and the OR of all enabled status bits drives one registered interrupt line for the whole port.

Software uses a simple single-cycle register port: a write strobe with address and data, and a combinational read-data output selected by the address. The enable register has a second address that takes masked writes, so one pin's enable can be changed without a read-modify-write.

Each pin's trigger bits decode into one of five detection modes: `TRIG_LVL_LOW`, `TRIG_LVL_HIGH`, `TRIG_RISE`, `TRIG_FALL` and `TRIG_ANY`. Writing the trigger word moves a pin from one mode to another. The move takes effect at the clock edge that captures the write and leaves the pin's status bit unchanged. In every mode a pin's cycle has two steps. The pin waits with status clear until its condition is seen. It then holds status set until a clear lands in a cycle with no new hit.

Top module: `gpint_port`

## Requirements
- R1: After reset the status, enable and trigger registers read 0, `irq` is low, and each pin's remembered previous level is 0.
- R2: Register map on `bus_addr`: status at 0x40 is read-only, and writes to it are ignored. Enable at 0x50 is read/write in bits 7:0. Trigger at 0x60 is read/write in bits 23:0, and bits 31:24 read 0. Clear at 0x70, the masked enable alias at 0xD0 and any unmapped address all read 0.
- R3: For pin n, trigger bit n is the polarity (1 = high or rising), bit 8+n selects edge sensing (1) or level sensing (0), and bit 16+n selects both edges. With edge select 0, the status bit sets at the clock edge after the pin level equals the polarity, and the both-edges bit is ignored.
- R4: With edge select 1 and both-edges 0, polarity 1 sets status when the pin is 1 and was 0 in the previous cycle. Polarity 0 sets status on a 1-to-0 change. The opposite edge has no effect.
- R5: With edge select 1 and both-edges 1, any change of the pin level sets status, whatever the polarity bit.
- R6: A status bit stays set until a write to 0x70 has a 1 in that bit position. Zero bits in the clear data leave the status unchanged.
- R7: When a clear and a new detection for the same pin fall in the same cycle, the status bit ends set. A level-sensed pin whose condition still holds therefore stays set through a clear.
- R8: Status bits set whether or not the pin is enabled. The enable only gates the interrupt.
- R9: `irq` is a register holding the OR of (status AND enable). It goes high one cycle after that product becomes nonzero and low one cycle after it becomes zero.
- R10: A write to 0xD0 updates only the enable bits whose mask bit in data bits 15:8 is 1, and loads them from data bits 7:0. The other enable bits keep their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_lvl | input | 8 | Synchronized pin levels |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Registered port interrupt |

## Verification
The bench sweeps every detection mode, plus a mixed per-pin configuration, under pin toggle patterns that change one bit at a time and several bits at once. It interleaves clears and masked enable writes, and compares status and `irq` every cycle with a model built from the requirements.

Directed checks cover five corner cases:
- A clear and a rising edge in the same cycle. A design that gave the clear priority would lose that event.
- A clear while a level condition holds. A design that let the clear win would let status drop for one cycle.
- An edge in the wrong direction, which would set status if polarity were ignored.
- The both-edges bit in level mode, which would turn level sensing into edge sensing if decoded wrongly.
- A masked write with a partial mask, which would corrupt neighbouring enables if the mask were ignored.

// File: rtl/gpint_pkg.sv
package gpint_pkg;

    // register byte offsets
    localparam int unsigned OFS_STATUS = 32'h40;
    localparam int unsigned OFS_ENABLE = 32'h50;
    localparam int unsigned OFS_TRIG   = 32'h60;
    localparam int unsigned OFS_CLEAR  = 32'h70;
    localparam int unsigned OFS_EN_MSK = 32'hD0;

    typedef enum logic [2:0] {
        TRIG_LVL_LOW  = 3'd0,
        TRIG_LVL_HIGH = 3'd1,
        TRIG_RISE     = 3'd2,
        TRIG_FALL     = 3'd3,
        TRIG_ANY      = 3'd4
    } trig_mode_e;

    function automatic trig_mode_e decode_mode(input logic pol, input logic edg,
                                               input logic both);
        trig_mode_e m;
        if (!edg)      m = pol ? TRIG_LVL_HIGH : TRIG_LVL_LOW;
        else if (both) m = TRIG_ANY;
        else           m = pol ? TRIG_RISE : TRIG_FALL;
        return m;
    endfunction

endpackage

// File: rtl/gpint_regs.sv
module gpint_regs
    import gpint_pkg::*;
#(
    parameter int NPIN = 8,
    parameter int AW   = 8,
    parameter int DW   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic [NPIN-1:0]   sts_q,
    output logic [NPIN-1:0]   en_q,
    output logic [3*NPIN-1:0] trig_q,
    output logic [NPIN-1:0]   clr_vec,
    output logic [DW-1:0]     bus_rdata
);
    localparam int TW = 3 * NPIN;

    logic            hit_en, hit_trig, hit_clr, hit_msk;
    logic [NPIN-1:0] msk_sel, msk_val;

    assign hit_en   = bus_we && (bus_addr == AW'(OFS_ENABLE));
    assign hit_trig = bus_we && (bus_addr == AW'(OFS_TRIG));
    assign hit_clr  = bus_we && (bus_addr == AW'(OFS_CLEAR));
    assign hit_msk  = bus_we && (bus_addr == AW'(OFS_EN_MSK));

    assign msk_sel  = bus_wdata[2*NPIN-1:NPIN];
    assign msk_val  = bus_wdata[NPIN-1:0];
    assign clr_vec  = hit_clr ? bus_wdata[NPIN-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            trig_q <= '0;
        end else begin
            if (hit_en)
                en_q <= bus_wdata[NPIN-1:0];
            else if (hit_msk)
                en_q <= (en_q & ~msk_sel) | (msk_val & msk_sel);
            if (hit_trig)
                trig_q <= bus_wdata[TW-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(OFS_STATUS))      bus_rdata = DW'(sts_q);
        else if (bus_addr == AW'(OFS_ENABLE)) bus_rdata = DW'(en_q);
        else if (bus_addr == AW'(OFS_TRIG))   bus_rdata = DW'(trig_q);
    end

endmodule

// File: rtl/gpint_pin_det.sv
module gpint_pin_det
    import gpint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_lvl,
    input  logic pol,
    input  logic edg,
    input  logic both,
    input  logic clr,
    output logic sts
);
    trig_mode_e mode;
    logic       prev_q;
    logic       hit;

    assign mode = decode_mode(pol, edg, both);

    // detection condition per mode
    always_comb begin
        hit = 1'b0;
        unique case (mode)
            TRIG_LVL_LOW:  hit = ~pin_lvl;
            TRIG_LVL_HIGH: hit = pin_lvl;
            TRIG_RISE:     hit = pin_lvl & ~prev_q;
            TRIG_FALL:     hit = ~pin_lvl & prev_q;
            TRIG_ANY:      hit = pin_lvl ^ prev_q;
            default:       hit = 1'b0;
        endcase
    end

    // a new hit wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            sts    <= 1'b0;
        end else begin
            prev_q <= pin_lvl;
            sts    <= (sts & ~clr) | hit;
        end
    end

endmodule

// File: rtl/gpint_port.sv
module gpint_port
    import gpint_pkg::*;
#(
    parameter int NPIN = 8,
    parameter int AW   = 8,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_lvl,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            irq
);
    logic [NPIN-1:0]   sts_q;
    logic [NPIN-1:0]   en_q;
    logic [3*NPIN-1:0] trig_q;
    logic [NPIN-1:0]   clr_vec;

    gpint_regs #(.NPIN(NPIN), .AW(AW), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .sts_q    (sts_q),
        .en_q     (en_q),
        .trig_q   (trig_q),
        .clr_vec  (clr_vec),
        .bus_rdata(bus_rdata)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        gpint_pin_det u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_lvl(pin_lvl[i]),
            .pol    (trig_q[i]),
            .edg    (trig_q[NPIN+i]),
            .both   (trig_q[2*NPIN+i]),
            .clr    (clr_vec[i]),
            .sts    (sts_q[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(sts_q & en_q);
    end

endmodule

// File: rtl/gpint_port_chk.sv
module gpint_port_chk #(
    parameter int NPIN = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NPIN-1:0]   pin_lvl,
    input logic [3*NPIN-1:0] trig_q,
    input logic [NPIN-1:0]   sts_q,
    input logic [NPIN-1:0]   en_q,
    input logic [NPIN-1:0]   clr_vec,
    input logic              irq
);
    logic [NPIN-1:0] pin_d;
    logic [NPIN-1:0] exp_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_d <= '0;
        else        pin_d <= pin_lvl;
    end

    always_comb begin
        for (int n = 0; n < NPIN; n++) begin
            if (trig_q[NPIN+n])
                exp_hit[n] = trig_q[2*NPIN+n] ? (pin_lvl[n] ^ pin_d[n]) :
                             (trig_q[n] ? (pin_lvl[n] & ~pin_d[n]) : (~pin_lvl[n] & pin_d[n]));
            else
                exp_hit[n] = ~(pin_lvl[n] ^ trig_q[n]);
        end
    end

    // R3 R4 R5 R7: every detected condition is set in status next cycle
    a_r4_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(exp_hit) & ~sts_q) == '0));

    // R3 R4 R5: status never rises without a detected condition
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(exp_hit)) == '0));

    // R6: a set status bit survives unless cleared
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(sts_q) & ~$past(clr_vec) & ~sts_q) == '0));

    // R9: interrupt follows enabled status one cycle later
    a_r9_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == |($past(sts_q) & $past(en_q))));

endmodule

bind gpint_port gpint_port_chk #(.NPIN(NPIN)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_lvl(pin_lvl),
    .trig_q (trig_q),
    .sts_q  (sts_q),
    .en_q   (en_q),
    .clr_vec(clr_vec),
    .irq    (irq)
);

// File: tb/test_gpint_port.sv
module test_gpint_port;
    localparam int PERIOD = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_lvl = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    gpint_port i_gpint_port (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // reference model built from the requirements
    logic [7:0]  m_sts, m_en, m_prev, m_hit, m_clr;
    logic [23:0] m_trig;
    logic        m_irq;

    always_comb begin
        for (int n = 0; n < 8; n++) begin
            if (!m_trig[8+n])       m_hit[n] = (pin_lvl[n] == m_trig[n]);    // R3
            else if (m_trig[16+n])  m_hit[n] = (pin_lvl[n] != m_prev[n]);    // R5
            else if (m_trig[n])     m_hit[n] = pin_lvl[n] && !m_prev[n];     // R4
            else                    m_hit[n] = !pin_lvl[n] && m_prev[n];
        end
        m_clr = (bus_we && bus_addr == 8'h70) ? bus_wdata[7:0] : 8'h00;
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sts <= '0; m_en <= '0; m_prev <= '0; m_trig <= '0; m_irq <= 1'b0;
        end else begin
            m_sts  <= (m_sts & ~m_clr) | m_hit;
            m_prev <= pin_lvl;
            m_irq  <= |(m_sts & m_en);
            if (bus_we && bus_addr == 8'h50) m_en <= bus_wdata[7:0];
            if (bus_we && bus_addr == 8'hD0)
                m_en <= (m_en & ~bus_wdata[15:8]) | (bus_wdata[7:0] & bus_wdata[15:8]);
            if (bus_we && bus_addr == 8'h60) m_trig <= bus_wdata[23:0];
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic [7:0] p, input logic we, input logic [7:0] a,
                       input logic [31:0] d);
        @(negedge clk);
        pin_lvl = p; bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #(PERIOD/4);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic check_state(input string tag);
        logic [31:0] v;
        rd(8'h40, v);
        check(tag, v, {24'h0, m_sts});
        check("R9", {31'h0, irq}, {31'h0, m_irq});
    endtask

    function automatic logic [2:0] mode_bits(input int m);
        case (m)
            0: return 3'b000;   // level low
            1: return 3'b001;   // level high
            2: return 3'b011;   // rising
            3: return 3'b010;   // falling
            4: return 3'b110;   // both edges, polarity 0
            5: return 3'b111;   // both edges, polarity 1
            6: return 3'b100;   // level low with both-edges bit set
            default: return 3'b000;
        endcase
    endfunction

    initial begin
        #(PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  pins;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #(PERIOD/4);
        // R1 reset values
        rd(8'h40, v); check("R1 status", v, 32'h0);
        rd(8'h50, v); check("R1 enable", v, 32'h0);
        rd(8'h60, v); check("R1 trigger", v, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);

        // R2 map; trigger 0 = level low, so status fills while pins are 0
        cyc(8'h00, 1'b1, 8'h50, 32'h0000_00A5);
        rd(8'h50, v); check("R2 enable rw", v, 32'h0000_00A5);
        cyc(8'h00, 1'b1, 8'h60, 32'hFFFF_FFFF);
        rd(8'h60, v); check("R2 trigger width", v, 32'h00FF_FFFF);
        rd(8'h70, v); check("R2 clear reads 0", v, 32'h0);
        rd(8'hD0, v); check("R2 alias reads 0", v, 32'h0);
        rd(8'h44, v); check("R2 unmapped", v, 32'h0);
        cyc(8'h00, 1'b1, 8'h70, 32'h0000_00FF);
        cyc(8'h00, 1'b1, 8'h40, 32'h0000_005A);
        check_state("R2 status write ignored");
        rd(8'h40, v); check("R2 status stays clear", v, 32'h0);

        // R10 masked enable: mask F0 values 0F -> A5 becomes 05
        cyc(8'h00, 1'b1, 8'hD0, 32'h0000_F00F);
        rd(8'h50, v); check("R10 masked write", v, 32'h0000_0005);

        // R3 level low with both-edges bit ignored when edge select is 0
        cyc(8'h00, 1'b1, 8'h60, 32'h00FF_0000);
        cyc(8'h00, 1'b0, 8'h00, 32'h0);
        rd(8'h40, v); check("R3 level low sets", v, 32'h0000_00FF);
        // R7 clear while level holds
        cyc(8'h00, 1'b1, 8'h70, 32'h0000_00FF);
        rd(8'h40, v); check("R7 level survives clear", v, 32'h0000_00FF);
        check("R9 irq high", {31'h0, irq}, 32'h1);

        // rising on all pins
        cyc(8'h00, 1'b1, 8'h60, 32'h0000_FFFF);
        cyc(8'h00, 1'b1, 8'h70, 32'h0000_00FF);
        rd(8'h40, v); check("R6 clear", v, 32'h0);
        cyc(8'h02, 1'b1, 8'h70, 32'h0000_00FF);
        rd(8'h40, v); check("R7 clear collides with edge", v, 32'h0000_0002);
        cyc(8'h02, 1'b1, 8'h70, 32'h0000_0001);
        rd(8'h40, v); check("R6 zero bits keep", v, 32'h0000_0002);
        cyc(8'h00, 1'b0, 8'h00, 32'h0);
        rd(8'h40, v); check("R4 opposite edge ignored", v, 32'h0000_0002);
        check("R8 disabled pin no irq", {31'h0, irq}, 32'h0);
        cyc(8'h00, 1'b1, 8'hD0, 32'h0000_0202);
        cyc(8'h00, 1'b0, 8'h00, 32'h0);
        check("R9 irq after enable", {31'h0, irq}, 32'h1);
        cyc(8'h00, 1'b1, 8'h70, 32'h0000_0002);
        cyc(8'h00, 1'b0, 8'h00, 32'h0);
        check("R9 irq drops", {31'h0, irq}, 32'h0);

        // R5 both edges with polarity 0
        cyc(8'h00, 1'b1, 8'h60, 32'h00FF_FF00);
        cyc(8'h08, 1'b0, 8'h00, 32'h0);
        rd(8'h40, v); check("R5 up edge", v, 32'h0000_0008);
        cyc(8'h08, 1'b1, 8'h70, 32'h0000_00FF);
        cyc(8'h00, 1'b0, 8'h00, 32'h0);
        rd(8'h40, v); check("R5 down edge", v, 32'h0000_0008);

        // sweep modes against the model
        pins = pin_lvl;
        for (int s = 0; s < 8; s++) begin
            logic [23:0] tw;
            string       tag;
            tw = '0;
            for (int n = 0; n < 8; n++) begin
                logic [2:0] b;
                b = (s == 7) ? mode_bits((n + s) % 7) : mode_bits(s);
                tw[n] = b[0]; tw[8+n] = b[1]; tw[16+n] = b[2];
            end
            tag = (s == 2 || s == 3) ? "R4 sweep" :
                  (s == 4 || s == 5) ? "R5 sweep" : "R3 sweep";
            cyc(pins, 1'b1, 8'h60, {8'h0, tw});
            cyc(pins, 1'b1, 8'h50, {24'h0, 8'h3C ^ 8'(s * 17)});
            cyc(pins, 1'b1, 8'h70, 32'h0000_00FF);
            for (int k = 0; k < 48; k++) begin
                if (k % 3 == 0)      pins = pins ^ (8'h01 << (k % 8));
                else if (k % 3 == 2) pins = pins ^ 8'((k * 29 + s * 7) & 8'hFF);
                if (k % 6 == 5)
                    cyc(pins, 1'b1, 8'h70, {24'h0, 8'((k * 13) & 8'hFF)});
                else if (k % 11 == 10)
                    cyc(pins, 1'b1, 8'hD0, {16'h0, 8'(k * 7), 8'(k * 3)});
                else
                    cyc(pins, 1'b0, 8'h00, 32'h0);
                check_state(tag);
                if (k % 11 == 10) begin
                    rd(8'h50, v); check("R10 sweep", v, {24'h0, m_en});
                end
            end
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule